// File: doc/BRIEF.md
# Secured OTP Controller

This block sits behind the command front end of a serial flash. It watches the chip select, serial clock and serial data lines and decodes three single-byte commands: one that locks the customer portion of the one-time-programmable (OTP) region, one that enters secured mode and one that leaves it. It holds the security register. Bit 0 of that register shows the factory lock and is captured from an input while reset is held. Bit 1 is the customer lock. It can only be set, and only a power-on reset clears it.

The block also gates program requests. Outside secured mode every request is routed to the main array. Inside secured mode the target is a 4K-bit OTP region addressed from 0x000 to 0x1FF. The serial-number slice at 0x000 to 0x00F can never be programmed by the customer. The customer slice at 0x010 to 0x1FF can be programmed only while neither lock bit is set. Each request gets a registered response one cycle later, with separate allow flags for the main array and for the OTP region.

All serial inputs are brought into the system clock domain before they are decoded. A command counts only when chip select rises exactly after the eighth serial clock rising edge.

Top module: `otp_secure_ctrl`

## Requirements
- R1: After power-on reset, security register bit 1 is 0, bits 7..2 are 0, bit 0 equals `factory_lock_i` as held during reset, and the block is outside secured mode.
- R2: Opcode 0x2F, shifted MSB first on serial clock rising edges with exactly 8 edges before chip select rises, sets security register bit 1. No write-enable step is needed.
- R3: Once security register bit 1 is 1, it stays 1 through any command and through `rst_n`. Only `por_n` clears it.
- R4: A command framed with any number of serial clock edges other than 8 (for example 7, 9 or 16) changes no state.
- R5: Opcode 0xB1 enters secured mode and opcode 0xC1 leaves it. Serial clock idle-low and idle-high framing are both accepted.
- R6: In secured mode, every program request gets `array_ok_o` = 0.
- R7: Outside secured mode, every program request gets `array_ok_o` = 1 and `otp_ok_o` = 0.
- R8: Requests to addresses 0x000 through 0x00F never get `otp_ok_o` = 1.
- R9: In secured mode, a request gets `otp_ok_o` = 1 exactly when its address lies in 0x010..0x1FF and both security register bits 1 and 0 are 0. Addresses above 0x1FF are refused.
- R10: Security register bit 0 is never changed by any command.
- R11: Pulsing `rst_n` leaves secured mode but keeps security register bit 1.
- R12: Opcodes other than 0x2F, 0xB1 and 0xC1 change no state.
- R13: `prog_rsp_o` pulses for one cycle, exactly one cycle after `prog_req_i`. At most one of `array_ok_o` and `otp_ok_o` is 1, and only while `prog_rsp_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| por_n | input | 1 | Asynchronous active-low power-on reset; the only way to clear the customer lock |
| factory_lock_i | input | 1 | Factory lock level, captured while reset is held |
| cs_n_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in, MSB first |
| prog_req_i | input | 1 | Program request strobe |
| prog_addr_i | input | ADDR_W | Program request address |
| sec_reg_o | output | SR_W | Security register: bit 0 factory lock, bit 1 customer lock, other bits 0 |
| prog_rsp_o | output | 1 | Response strobe for a program request |
| array_ok_o | output | 1 | Main-array program allowed |
| otp_ok_o | output | 1 | OTP program allowed |

## Verification
A program decision is registered once, so the monitor compares it on the falling edge that follows the rising edge that captured the request. Any response that arrives with no pending expectation is reported as a failure. A serial command passes through two synchronizer stages, one edge-detect stage and one command register before the state changes, so the new state is visible four system clocks after chip select rises. The bench waits eight clocks after every frame before it checks the security register or issues requests. Commands that must be ignored are checked at the ports: the bench reads the security register and then issues program requests whose allow flags would differ if secured mode or either lock bit had moved.

// File: rtl/otp_secure_pkg.sv
package otp_secure_pkg;
  localparam int OP_W = 8;
  typedef logic [OP_W-1:0] opcode_t;
  localparam opcode_t OP_LOCK_CUST = 8'h2F;
  localparam opcode_t OP_SEC_ENTER = 8'hB1;
  localparam opcode_t OP_SEC_EXIT  = 8'hC1;
endpackage

// File: rtl/otp_sync.sv
module otp_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/otp_cmd_rx.sv
module otp_cmd_rx
  import otp_secure_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cs_n,
  input  logic    sclk,
  input  logic    sdi,
  output logic    cmd_vld,
  output opcode_t cmd_op
);
  localparam int CNT_MAX = OP_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             cs_d, sclk_d;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  opcode_t          sh_q, sh_n;
  logic             vld_q, vld_n;
  opcode_t          op_q, op_n;
  logic             cs_rise, cs_fall, sclk_rise;

  assign cs_rise   = cs_n & ~cs_d;
  assign cs_fall   = ~cs_n & cs_d;
  assign sclk_rise = sclk & ~sclk_d & ~cs_n;

  always_comb begin
    cnt_n = cnt_q;
    sh_n  = sh_q;
    vld_n = 1'b0;
    op_n  = op_q;
    if (cs_fall) begin
      cnt_n = '0;
    end else if (sclk_rise) begin
      sh_n = {sh_q[OP_W-2:0], sdi};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_n = cnt_q + 1'b1;
    end
    if (cs_rise && cnt_q == CNT_W'(OP_W)) begin
      vld_n = 1'b1;
      op_n  = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
      op_q   <= '0;
    end else begin
      cs_d   <= cs_n;
      sclk_d <= sclk;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      vld_q  <= vld_n;
      op_q   <= op_n;
    end

  assign cmd_vld = vld_q;
  assign cmd_op  = op_q;
endmodule

// File: rtl/otp_prog_gate.sv
module otp_prog_gate #(
  parameter int              ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] SN_LAST  = 'h00F,
  parameter logic [ADDR_W-1:0] OTP_LAST = 'h1FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              secured,
  input  logic              locked,
  output logic              rsp,
  output logic              arr_ok,
  output logic              otp_ok
);
  logic rsp_n, arr_n, otp_n, in_cust;

  assign in_cust = (addr > SN_LAST) && (addr <= OTP_LAST);

  always_comb begin
    rsp_n = req;
    arr_n = req & ~secured;
    otp_n = req & secured & in_cust & ~locked;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsp    <= 1'b0;
      arr_ok <= 1'b0;
      otp_ok <= 1'b0;
    end else begin
      rsp    <= rsp_n;
      arr_ok <= arr_n;
      otp_ok <= otp_n;
    end
endmodule

// File: rtl/otp_secure_ctrl.sv
module otp_secure_ctrl
  import otp_secure_pkg::*;
#(
  parameter int                ADDR_W      = 24,
  parameter int                SR_W        = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] SN_LAST     = 'h00F,
  parameter logic [ADDR_W-1:0] OTP_LAST    = 'h1FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              factory_lock_i,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              prog_req_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  output logic [SR_W-1:0]   sec_reg_o,
  output logic              prog_rsp_o,
  output logic              array_ok_o,
  output logic              otp_ok_o
);
  logic    rst_sync_n;
  logic    cs_s, sclk_s, sdi_s;
  logic    cmd_vld;
  opcode_t cmd_op;
  logic    sec_q, sec_n;
  logic    cust_q, cust_n;
  logic    fact_q;

  otp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  otp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_pin_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .d({cs_n_i, sclk_i, sdi_i}), .q({cs_s, sclk_s, sdi_s})
  );

  otp_cmd_rx u_rx (
    .clk(clk), .rst_n(rst_sync_n), .cs_n(cs_s), .sclk(sclk_s), .sdi(sdi_s),
    .cmd_vld(cmd_vld), .cmd_op(cmd_op)
  );

  always_comb begin
    sec_n  = sec_q;
    cust_n = cust_q;
    if (cmd_vld) begin
      unique case (cmd_op)
        OP_SEC_ENTER: sec_n  = 1'b1;
        OP_SEC_EXIT:  sec_n  = 1'b0;
        OP_LOCK_CUST: cust_n = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n)
    if (!rst_sync_n) sec_q <= 1'b0;
    else             sec_q <= sec_n;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) cust_q <= 1'b0;
    else        cust_q <= cust_n;

  always_ff @(posedge clk)
    if (!rst_sync_n) fact_q <= factory_lock_i;

  always_comb begin
    sec_reg_o    = '0;
    sec_reg_o[0] = fact_q;
    sec_reg_o[1] = cust_q;
  end

  otp_prog_gate #(.ADDR_W(ADDR_W), .SN_LAST(SN_LAST), .OTP_LAST(OTP_LAST)) u_gate (
    .clk(clk), .rst_n(rst_sync_n), .req(prog_req_i), .addr(prog_addr_i),
    .secured(sec_q), .locked(fact_q | cust_q),
    .rsp(prog_rsp_o), .arr_ok(array_ok_o), .otp_ok(otp_ok_o)
  );
endmodule

// File: rtl/otp_secure_chk.sv
module otp_secure_chk #(
  parameter int                ADDR_W  = 24,
  parameter int                SR_W    = 8,
  parameter logic [ADDR_W-1:0] SN_LAST = 'h00F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_n,
  input logic              prog_req,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [SR_W-1:0]   sec_reg,
  input logic              prog_rsp,
  input logic              array_ok,
  input logic              otp_ok
);
  AST_CUST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    sec_reg[1] |=> sec_reg[1]); // R3
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> prog_rsp); // R13
  AST_NO_RSP_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_req |=> !prog_rsp); // R13
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (array_ok || otp_ok) |-> (prog_rsp && !(array_ok && otp_ok))); // R13
  AST_OTP_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    otp_ok |-> (!$past(sec_reg[0]) && !$past(sec_reg[1]))); // R9
  AST_SERIAL_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    otp_ok |-> ($past(prog_addr) > SN_LAST)); // R8
  AST_FACTORY_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(sec_reg[0])); // R10
endmodule

bind otp_secure_ctrl otp_secure_chk #(.ADDR_W(ADDR_W), .SR_W(SR_W), .SN_LAST(SN_LAST)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .por_n(por_n), .prog_req(prog_req_i),
  .prog_addr(prog_addr_i), .sec_reg(sec_reg_o), .prog_rsp(prog_rsp_o),
  .array_ok(array_ok_o), .otp_ok(otp_ok_o)
);

// File: tb/test_otp_secure_ctrl.sv
module test_otp_secure_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, por_n, factory_lock_i;
  logic        cs_n_i, sclk_i, sdi_i, prog_req_i;
  logic [23:0] prog_addr_i;
  logic [7:0]  sec_reg_o;
  logic        prog_rsp_o, array_ok_o, otp_ok_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct { logic arr; logic otp; string tag; } exp_t;
  exp_t q[$];

  bit m_sec, m_cust, m_fact;

  always #5 clk = ~clk;

  otp_secure_ctrl i_otp_secure_ctrl (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .factory_lock_i(factory_lock_i),
    .cs_n_i(cs_n_i), .sclk_i(sclk_i), .sdi_i(sdi_i), .prog_req_i(prog_req_i),
    .prog_addr_i(prog_addr_i), .sec_reg_o(sec_reg_o), .prog_rsp_o(prog_rsp_o),
    .array_ok_o(array_ok_o), .otp_ok_o(otp_ok_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected decision per response strobe
  always @(negedge clk) begin
    if (!done && prog_rsp_o) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R13 actual unexpected response expected none");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, {30'd0, array_ok_o, otp_ok_o}, {30'd0, e.arr, e.otp});
      end
    end
  end

  task automatic prog(input logic [23:0] a, input string tag);
    exp_t e;
    e.arr = !m_sec;
    e.otp = m_sec && a > 24'h00F && a <= 24'h1FF && !m_cust && !m_fact;
    e.tag = tag;
    @(negedge clk);
    q.push_back(e);
    prog_req_i = 1'b1; prog_addr_i = a;
    @(negedge clk);
    prog_req_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic spi(input logic [15:0] v, input int n, input bit mode3);
    @(negedge clk); sclk_i = mode3;
    repeat (4) @(negedge clk); cs_n_i = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (mode3) sclk_i = 1'b0;
      sdi_i = v[n-1-i];
      repeat (4) @(negedge clk); sclk_i = 1'b1;
      repeat (4) @(negedge clk);
      if (!mode3) sclk_i = 1'b0;
    end
    repeat (4) @(negedge clk); cs_n_i = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic do_reset(input bit por, input bit fact);
    @(negedge clk);
    rst_n = 1'b0; if (por) por_n = 1'b0;
    factory_lock_i = fact;
    repeat (5) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    repeat (6) @(negedge clk);
    m_sec = 1'b0; m_fact = fact; if (por) m_cust = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; por_n = 1'b0; factory_lock_i = 1'b0;
    cs_n_i = 1'b1; sclk_i = 1'b0; sdi_i = 1'b0;
    prog_req_i = 1'b0; prog_addr_i = '0;
    do_reset(1'b1, 1'b0);
    chk("R1 reset register", 32'(sec_reg_o), 32'h00);
    prog(24'h001234, "R7 array outside secured");
    prog(24'h000020, "R7 otp range outside secured");
    spi(16'h00B1, 7, 1'b0);                        // R4 short frame
    prog(24'h000100, "R4 seven-bit enter ignored");
    spi(16'h00B1, 8, 1'b1); m_sec = 1'b1;          // R5 mode 3 enter
    prog(24'h001234, "R6 array refused in secured");
    prog(24'h000005, "R8 serial range refused");
    prog(24'h000010, "R9 customer low bound");
    prog(24'h0001FF, "R9 customer high bound");
    prog(24'h000200, "R9 above otp refused");
    spi(16'h0055, 8, 1'b0);                        // R12 unknown opcode
    chk("R12 unknown opcode register", 32'(sec_reg_o), 32'h00);
    prog(24'h000100, "R12 unknown keeps secured");
    spi(16'h005E, 9, 1'b0);                        // 0x2F then one extra bit
    chk("R4 nine-bit lock ignored", 32'(sec_reg_o), 32'h00);
    spi(16'h2F2F, 16, 1'b0);
    chk("R4 sixteen-bit lock ignored", 32'(sec_reg_o), 32'h00);
    spi(16'h002F, 8, 1'b0); m_cust = 1'b1;
    chk("R2 lock set without write enable", 32'(sec_reg_o), 32'h02);
    prog(24'h000100, "R9 customer lock refuses otp");
    prog(24'h000003, "R8 serial range after lock");
    spi(16'h00C1, 8, 1'b0); m_sec = 1'b0;
    prog(24'h000100, "R5 exit returns to array");
    chk("R10 bit0 unchanged by commands", 32'(sec_reg_o[0]), 32'h0);
    spi(16'h00B1, 8, 1'b0); m_sec = 1'b1;
    prog(24'h000400, "R5 idle-low enter");
    do_reset(1'b0, 1'b0);
    chk("R3 R11 lock survives rst_n", 32'(sec_reg_o), 32'h02);
    prog(24'h001000, "R11 rst_n leaves secured");
    do_reset(1'b1, 1'b1);
    chk("R1 factory bit loaded", 32'(sec_reg_o), 32'h01);
    spi(16'h00B1, 8, 1'b0); m_sec = 1'b1;
    prog(24'h000100, "R9 factory lock refuses otp");
    spi(16'h002F, 8, 1'b0); m_cust = 1'b1;
    chk("R10 factory bit kept after lock command", 32'(sec_reg_o), 32'h03);
    repeat (4) @(negedge clk);
    chk("R13 no pending responses", 32'(q.size()), 32'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule